// File: doc/BRIEF.md
# Serial Transceiver with Multidrop Addressing and Channel Loopback

This block is a full-duplex asynchronous serial port. It sits behind a small register interface: software sets the character format and the baud divisor, writes characters into a single transmit holding register, and reads received characters from a single receive buffer. A free-running divider produces a tick at sixteen times the bit rate. Both shift engines run from that tick. The receiver takes its bit decision from three samples around the centre of each bit.

Character length can be 5 to 8 data bits. The ninth bit position can carry parity, or in multidrop mode an address/data flag. The receiver flags parity errors, missing stop bits and overruns. It also recognises a line break, meaning a whole frame of zeros. Software can force a break on the transmit line.

A channel-mode field sets how the transmit and receive paths connect. In normal mode each path works alone. In echo mode the receive line is mirrored onto the transmit pin and reception continues. In local loopback the transmitter feeds the receiver internally and the pin stays idle. In remote loopback the pin is mirrored and the receiver sees an idle line. A single interrupt output is the OR of the status bits that are enabled in a mask register.

Top module: `uart_mdl`

## Requirements
- R1: After reset `txd` is 1, `irq` is 0, and the status register (address 4) reads 0x0006: bit1 is holding register empty, bit2 is transmitter idle, all others 0.
- R2: One bit lasts 16×D clock cycles on `txd`, where D is the divisor in register 1. A start bit is a low level.
- R3: A frame is sent as a start bit (0), then the data bits LSB first, then the optional ninth bit, then one stop bit (1). The length code in control bits [1:0] selects 5 + code data bits. Data is written to register 2, bits [7:0].
- R4: With parity enabled (control bit2) and multidrop off, the ninth bit is the even parity of the data bits. When control bit3 is set it is the odd parity instead.
- R5: A received character appears in register 3, bits [7:0] with the ninth bit in bit 8, and sets status bit0. Reading register 3 clears bit0. A parity mismatch sets status bit3.
- R6: A received stop bit of 0 in a frame that is not all zeros sets the framing error, status bit4.
- R7: A character that completes while status bit0 is still set sets the overrun flag, status bit5. The buffer then holds the newer character.
- R8: Control bit7 in normal mode drives `txd` low for as long as the bit is set.
- R9: A received frame whose start, data, ninth and stop bits are all 0 sets the break flag, status bit6. It delivers no character and does not set the framing error. Writing 1 to status bits 3 to 7 clears them.
- R10: In echo mode (control bits [6:5] = 1) `txd` copies `rxd` three clock cycles later, and the character is still received.
- R11: In local loopback (mode 2) `txd` stays 1 and the receiver decodes what the transmitter sends.
- R12: In remote loopback (mode 3) `txd` copies `rxd` three cycles later and no character is received.
- R13: Multidrop mode (control bit4) sends bit 8 of the written data as the ninth bit. On receive, a ninth bit of 1 sets status bit7 and appears in bit 8 of register 3.
- R14: `irq` is 1 exactly when some status bit is 1 and its bit in the mask register (address 5) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, registered |
| irq | output | 1 | Masked status interrupt |

## Verification
The mirror and idle-line properties assume that the channel-mode and break control bits stay fixed for at least one cycle. This is so they can be related to `txd` on the following edge. The bench waits several cycles after every control write before it enables its per-cycle line comparisons. The receive decoding assumes `rxd` changes no faster than one bit time and that the divisor is not changed during a frame. For that reason the bench drives whole frames at exactly 16×D cycles per bit, and it changes the divisor only when the transmitter reports idle.

// File: rtl/uart_mdl_pkg.sv
package uart_mdl_pkg;
  typedef enum logic [1:0] {CH_NORMAL = 2'd0, CH_ECHO = 2'd1, CH_LOCAL = 2'd2, CH_REMOTE = 2'd3} chmode_e;
  localparam int FRAME_W = 11;

  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // total bits in a frame including start and stop
  function automatic logic [3:0] frame_len(input logic [1:0] code, input logic nen);
    return 4'd2 + data_len(code) + {3'b000, nen};
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] code, input logic odd);
    logic [7:0] m;
    m = 8'hFF >> (2'd3 - code);
    return (^(d & m)) ^ odd;
  endfunction

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // LSB-first serial image: start, data, optional ninth, stop, idle ones
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d, input logic [1:0] code,
                                                     input logic nen, input logic nval);
    logic [FRAME_W-1:0] f;
    int n;
    f = '1;
    f[0] = 1'b0;
    n = int'(data_len(code));
    for (int i = 0; i < 8; i++) if (i < n) f[i+1] = d[i];
    if (nen) f[n+1] = nval;
    return f;
  endfunction
endpackage

// File: rtl/uart_mdl_baud.sv
module uart_mdl_baud #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign tick = (nxt >= {1'b0, div});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_mdl_tx.sv
module uart_mdl_tx
  import uart_mdl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [3:0]         nbits,
  output logic               busy,
  output logic               take,
  output logic               line
);
  logic [FRAME_W-1:0] sh;
  logic [3:0]         left, sub;

  assign take = tick && start && !busy;
  assign line = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sh <= '1; left <= '0; sub <= '0;
    end else if (take) begin
      busy <= 1'b1; sh <= frame; left <= nbits - 1'b1; sub <= '0;
    end else if (busy && tick) begin
      if (sub == 4'd15) begin
        sub <= '0;
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        if (left == '0) busy <= 1'b0;
        else            left <= left - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_mdl_rx.sv
module uart_mdl_rx
  import uart_mdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxin,
  input  logic [1:0] code,
  input  logic       nen,
  output logic       done,
  output logic       brk,
  output logic [7:0] data,
  output logic       ninth,
  output logic       stop_ok
);
  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAITHI} rxst_e;
  rxst_e st;
  logic [FRAME_W-1:0] sh, cur;
  logic [3:0] sub, idx, last;
  logic [1:0] v;
  logic maj, all_zero;
  logic [7:0] dat_c;
  int n;

  assign last = frame_len(code, nen) - 1'b1;
  assign maj  = majority3(v[0], v[1], rxin);
  assign n    = int'(data_len(code));

  always_comb begin
    cur = sh;
    cur[idx] = maj;
    all_zero = 1'b1;
    for (int i = 0; i < FRAME_W; i++) if (i <= int'(last) && cur[i]) all_zero = 1'b0;
    for (int i = 0; i < 8; i++) dat_c[i] = (i < n) ? cur[i+1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; sh <= '0; sub <= '0; idx <= '0; v <= '0;
      done <= 1'b0; brk <= 1'b0; data <= '0; ninth <= 1'b0; stop_ok <= 1'b1;
    end else begin
      done <= 1'b0;
      brk  <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!rxin) begin
            st <= RX_RUN; sub <= '0; idx <= '0; sh <= '0;
          end
          RX_RUN: begin
            sub <= sub + 1'b1;
            if (sub == 4'd7) v[0] <= rxin;
            if (sub == 4'd8) v[1] <= rxin;
            if (sub == 4'd9) begin
              if (idx == '0 && maj) st <= RX_IDLE;
              else begin
                sh <= cur;
                if (idx == last) begin
                  if (all_zero) begin
                    brk <= 1'b1; st <= RX_WAITHI;
                  end else begin
                    done <= 1'b1; st <= RX_IDLE;
                    data <= dat_c; ninth <= cur[n+1]; stop_ok <= cur[last];
                  end
                end else idx <= idx + 1'b1;
              end
            end
          end
          default: if (rxin) st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_mdl.sv
module uart_mdl
  import uart_mdl_pkg::*;
#(
  parameter int              DIVW    = 16,
  parameter logic [DIVW-1:0] DIV_RST = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  logic [7:0] ctrl, mask, status;
  logic [DIVW-1:0] div;
  logic [8:0] thr, rbuf;
  logic thr_full, rx_ready;
  logic [4:0] err;            // par, frm, ovr, brk, adr
  logic rx_s1, rx_s;
  logic tick, tx_busy, tx_take, tx_line, tx_ser;
  logic rx_done, rx_brk, rx_ninth, rx_stop, rx_in, nen, brk_cmd, rx_rd;
  logic [7:0] rx_data;
  logic [FRAME_W-1:0] frame;
  chmode_e mode;

  assign mode    = chmode_e'(ctrl[6:5]);
  assign brk_cmd = ctrl[7];
  assign nen     = ctrl[2] | ctrl[4];
  assign frame   = build_frame(thr[7:0], ctrl[1:0], nen,
                               ctrl[4] ? thr[8] : parity_of(thr[7:0], ctrl[1:0], ctrl[3]));
  assign tx_line = brk_cmd ? 1'b0 : tx_ser;
  assign rx_in   = (mode == CH_LOCAL) ? tx_line : (mode == CH_REMOTE) ? 1'b1 : rx_s;
  assign rx_rd   = reg_rd && reg_addr == 3'd3;
  assign status  = {err, 1'b0, 1'b0, rx_ready} | {5'b0, !tx_busy && !thr_full, !thr_full, 1'b0};
  assign irq     = |(status & mask);

  uart_mdl_baud #(.DIVW(DIVW)) u_baud (.clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

  uart_mdl_tx u_tx (.clk(clk), .rst_n(rst_n), .tick(tick), .start(thr_full), .frame(frame),
                    .nbits(frame_len(ctrl[1:0], nen)), .busy(tx_busy), .take(tx_take), .line(tx_ser));

  uart_mdl_rx u_rx (.clk(clk), .rst_n(rst_n), .tick(tick), .rxin(rx_in), .code(ctrl[1:0]), .nen(nen),
                    .done(rx_done), .brk(rx_brk), .data(rx_data), .ninth(rx_ninth), .stop_ok(rx_stop));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[7:0] = ctrl;
      3'd1: reg_rdata[DIVW-1:0] = div;
      3'd2: reg_rdata[8:0] = thr;
      3'd3: reg_rdata[8:0] = rbuf;
      3'd4: reg_rdata[7:0] = status;
      3'd5: reg_rdata[7:0] = mask;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s <= 1'b1; txd <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s  <= rx_s1;
      case (mode)
        CH_NORMAL: txd <= tx_line;
        CH_LOCAL:  txd <= 1'b1;
        default:   txd <= rx_s;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; div <= DIV_RST; mask <= '0; thr <= '0; thr_full <= 1'b0;
      rbuf <= '0; rx_ready <= 1'b0; err <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd0) ctrl <= reg_wdata[7:0];
      if (reg_wr && reg_addr == 3'd1) div  <= reg_wdata[DIVW-1:0];
      if (reg_wr && reg_addr == 3'd5) mask <= reg_wdata[7:0];
      if (tx_take) thr_full <= 1'b0;
      if (reg_wr && reg_addr == 3'd2) begin thr <= reg_wdata[8:0]; thr_full <= 1'b1; end
      if (reg_wr && reg_addr == 3'd4) err <= err & ~reg_wdata[7:3];
      if (rx_rd) rx_ready <= 1'b0;
      if (rx_done) begin
        rbuf <= {rx_ninth, rx_data};
        rx_ready <= 1'b1;
        if (rx_ready && !rx_rd) err[2] <= 1'b1;
        if (ctrl[2] && !ctrl[4] && rx_ninth != parity_of(rx_data, ctrl[1:0], ctrl[3])) err[0] <= 1'b1;
        if (!rx_stop) err[1] <= 1'b1;
        if (ctrl[4] && rx_ninth) err[4] <= 1'b1;
      end
      if (rx_brk) err[3] <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_mdl_chk.sv
module uart_mdl_chk
  import uart_mdl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       irq,
  input logic       rx_s,
  input chmode_e    mode,
  input logic       brk_cmd,
  input logic       tx_busy,
  input logic       rx_done,
  input logic       rx_ready,
  input logic       rx_rd,
  input logic [4:0] err,
  input logic [7:0] mask
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_NORMAL && !brk_cmd && !tx_busy) |=> txd);
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_NORMAL && brk_cmd) |=> !txd);
  a_r10_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_ECHO || mode == CH_REMOTE) |=> (txd == $past(rx_s)));
  a_r11_local_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_LOCAL) |=> txd);
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ready && !rx_rd) |=> err[2]);
  a_r14_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |-> !irq);
endmodule

bind uart_mdl uart_mdl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .irq(irq), .rx_s(rx_s), .mode(mode), .brk_cmd(brk_cmd),
  .tx_busy(tx_busy), .rx_done(rx_done), .rx_ready(rx_ready), .rx_rd(rx_rd), .err(err), .mask(mask)
);

// File: tb/tb_uart_mdl.sv
module tb_uart_mdl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, rxd = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic txd, irq;

  int vectors = 0, miscompares = 0, bitclk = 32;
  bit finished = 0, chk_mirror = 0, chk_high = 0;
  string mirror_req = "R10";
  logic h0 = 1'b1, h1 = 1'b1, h2 = 1'b1;

  uart_mdl dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
                .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin h2 <= h1; h1 <= h0; h0 <= rxd; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_mirror)    chk(txd === h2, mirror_req, int'(txd), int'(h2));
    else if (chk_high) chk(txd === 1'b1, "R11 line idle", int'(txd), 1);
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [15:0] mkctrl(int len, bit pen, bit odd, bit md, int mode, bit brk);
    return 16'((brk << 7) | (mode << 5) | (md << 4) | (odd << 3) | (pen << 2) | len);
  endfunction

  function automatic bit par(int d, int n, bit odd);
    int c = 0;
    for (int i = 0; i < n; i++) c += (d >> i) & 1;
    return bit'(c % 2) ^ odd;
  endfunction

  function automatic logic [10:0] mkframe(int d, int n, bit nen, bit nv, output int len);
    int val;
    len = n + 2 + int'(nen);
    val = (d & ((1 << n) - 1)) << 1;
    if (nen) val = val | (int'(nv) << (n + 1));
    val = val | (~0 << (len - 1));
    return val[10:0];
  endfunction

  task automatic grab(input int n, output logic [10:0] bits);
    int t = 0;
    bits = '1;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin bits[i] = txd; repeat (bitclk) @(negedge clk); end
  endtask

  task automatic send_rx(int d, int n, bit nen, bit nv, bit stop);
    logic [10:0] f;
    int len;
    f = mkframe(d, n, nen, nv, len);
    if (!stop) f[len-1] = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (bitclk - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic wait_status(int b, output bit seen);
    logic [15:0] s;
    seen = 0;
    for (int t = 0; t < 3000 && !seen; t++) begin rd(3'd4, s); seen = s[b]; end
  endtask

  task automatic tx_frame(string req, int d, int n, bit nen, bit nv);
    logic [10:0] got, exp;
    int len;
    exp = mkframe(d, n, nen, nv, len);
    wr(3'd2, 16'(d));
    grab(len, got);
    for (int i = len; i < 11; i++) got[i] = 1'b1;
    chk(got === exp, req, int'(got), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, r;
    bit seen;
    int c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(irq === 1'b0, "R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    rd(3'd4, s);
    chk(s === 16'h0006, "R1 status", int'(s), 6);

    // R2 bit length for two divisors
    wr(3'd1, 16'd2); wr(3'd0, mkctrl(3, 0, 0, 0, 0, 0));
    wr(3'd2, 16'h55);
    while (txd !== 1'b0) @(negedge clk);
    c = 0; while (txd === 1'b0) begin @(negedge clk); c++; end
    chk(c == 32, "R2 start width div2", c, 32);
    wait_status(2, seen);
    wr(3'd1, 16'd3); bitclk = 48;
    wr(3'd2, 16'h01);
    while (txd !== 1'b0) @(negedge clk);
    c = 0; while (txd === 1'b0) begin @(negedge clk); c++; end
    chk(c == 48, "R2 start width div3", c, 48);
    wait_status(2, seen);
    wr(3'd1, 16'd2); bitclk = 32;

    // R3 frame layout, 8 and 5 data bits
    tx_frame("R3 8-bit frame", 'hA3, 8, 0, 0);
    wr(3'd0, mkctrl(0, 0, 0, 0, 0, 0));
    tx_frame("R3 5-bit frame", 'h16, 5, 0, 0);
    // R4 parity
    wr(3'd0, mkctrl(2, 1, 0, 0, 0, 0));
    tx_frame("R4 even parity", 'h35, 7, 1, par('h35, 7, 0));
    wr(3'd0, mkctrl(1, 1, 1, 0, 0, 0));
    tx_frame("R4 odd parity", 'h2B, 6, 1, par('h2B, 6, 1));

    // R5 receive and parity error
    wr(3'd0, mkctrl(3, 1, 0, 0, 0, 0));
    send_rx('h6C, 8, 1, par('h6C, 8, 0), 1);
    rd(3'd4, s);
    chk(s[0] === 1'b1 && s[3] === 1'b0, "R5 good char status", int'(s), 1);
    rd(3'd3, r);
    chk(r[7:0] === 8'h6C, "R5 rx data", int'(r), 'h6C);
    rd(3'd4, s);
    chk(s[0] === 1'b0, "R5 read clears ready", int'(s[0]), 0);
    send_rx('h6C, 8, 1, !par('h6C, 8, 0), 1);
    rd(3'd4, s);
    chk(s[3] === 1'b1, "R5 parity error", int'(s), 'h08);
    rd(3'd3, r); wr(3'd4, 16'hF8);

    // R6 framing error
    wr(3'd0, mkctrl(3, 0, 0, 0, 0, 0));
    send_rx('h81, 8, 0, 0, 0);
    repeat (3 * bitclk) @(negedge clk);
    rd(3'd4, s);
    chk(s[4] === 1'b1, "R6 framing error", int'(s), 'h10);
    rd(3'd3, r); wr(3'd4, 16'hF8);

    // R7 overrun
    send_rx('h11, 8, 0, 0, 1);
    send_rx('h22, 8, 0, 0, 1);
    rd(3'd4, s);
    chk(s[5] === 1'b1, "R7 overrun flag", int'(s), 'h20);
    rd(3'd3, r);
    chk(r[7:0] === 8'h22, "R7 newer data kept", int'(r), 'h22);
    wr(3'd4, 16'hF8);

    // R8 break transmit
    wr(3'd0, mkctrl(3, 0, 0, 0, 0, 1));
    repeat (4) @(negedge clk);
    c = 0;
    for (int i = 0; i < 100; i++) begin if (txd !== 1'b0) c++; @(negedge clk); end
    chk(c == 0, "R8 break holds low", c, 0);
    wr(3'd0, mkctrl(3, 0, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    chk(txd === 1'b1, "R8 break released", int'(txd), 1);

    // R9 break detect
    @(negedge clk); rxd = 1'b0;
    repeat (12 * bitclk) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitclk) @(negedge clk);
    rd(3'd4, s);
    chk(s[6] === 1'b1 && s[0] === 1'b0 && s[4] === 1'b0, "R9 break flag", int'(s), 'h46);
    wr(3'd4, 16'hF8);
    rd(3'd4, s);
    chk(s[7:3] === 5'b0, "R9 w1c clears", int'(s), 6);

    // R10 echo
    wr(3'd0, mkctrl(3, 0, 0, 0, 1, 0));
    repeat (6) @(negedge clk);
    mirror_req = "R10 echo mirror"; chk_mirror = 1;
    send_rx('h3C, 8, 0, 0, 1);
    chk_mirror = 0;
    rd(3'd3, r);
    chk(r[7:0] === 8'h3C, "R10 echo still receives", int'(r), 'h3C);

    // R12 remote loopback
    wr(3'd0, mkctrl(3, 0, 0, 0, 3, 0));
    repeat (6) @(negedge clk);
    mirror_req = "R12 remote mirror"; chk_mirror = 1;
    send_rx('h5A, 8, 0, 0, 1);
    chk_mirror = 0;
    rd(3'd4, s);
    chk(s[0] === 1'b0, "R12 no char received", int'(s[0]), 0);

    // R11 + R13 local loopback with multidrop address flag
    wr(3'd0, mkctrl(3, 0, 0, 1, 2, 0));
    repeat (6) @(negedge clk);
    chk_high = 1;
    wr(3'd2, 16'h1A5);
    wait_status(0, seen);
    chk(seen, "R11 local loop delivers", int'(seen), 1);
    // R14 interrupt masking
    wr(3'd5, 16'h01);
    @(negedge clk);
    chk(irq === 1'b1, "R14 irq enabled", int'(irq), 1);
    wr(3'd5, 16'h00);
    @(negedge clk);
    chk(irq === 1'b0, "R14 irq masked", int'(irq), 0);
    rd(3'd4, s);
    chk(s[7] === 1'b1, "R13 address detected", int'(s), 'h80);
    rd(3'd3, r);
    chk(r[8:0] === 9'h1A5, "R13 rx flag and data", int'(r), 'h1A5);
    chk_high = 0;
    wr(3'd4, 16'hF8);

    // R13 multidrop transmit ninth bit
    wr(3'd0, mkctrl(3, 0, 0, 1, 0, 0));
    tx_frame("R13 data flag 0", 'h0C3, 8, 1, 0);
    tx_frame("R13 address flag 1", 'h1C3, 8, 1, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule